// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block serialises characters onto a single output line. A one-character holding register sits in front of the frame shifter, so the host can write the next character while the current one is still on the wire. When the shifter is free, the held character moves into it on a bit-rate strobe. It then goes out as a low start bit, 7 or 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The strobe comes from outside the block as a single-cycle pulse, once per bit period.

Two status flags are exported. The first reports that the holding register is empty. The second reports that the shifter has run dry. A select input chooses which of the two raises the transmit interrupt pulse. A character written while a frame is ending follows that frame with no idle bit in between.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, txd_o is 1, buf_empty_o is 1, shift_done_o is 1 and irq_o is 0.
- R2: A frame is a 0 start bit, then the data bits least significant bit first, then the optional parity bit, then the stop bits at 1. Each bit lasts exactly one strobe period, and txd_o changes only on a clock edge where bit_stb_i is 1. When no frame is active, txd_o is 1.
- R3: With len8_i at 0, seven data bits (wr_data_i[6:0]) are sent and wr_data_i[7] has no effect on the line. With len8_i at 1, all eight bits are sent.
- R4: With par_en_i at 1, a parity bit follows the data. It is chosen so that the number of ones in the sent data bits plus the parity bit is even when par_odd_i is 0 and odd when par_odd_i is 1. With par_en_i at 0, no parity bit is sent.
- R5: stop2_i at 0 sends one stop bit; stop2_i at 1 sends two.
- R6: buf_empty_o goes to 0 one cycle after a write. It returns to 1 on the strobe edge that moves the character into the shifter, which is the same edge where the start bit appears on txd_o.
- R7: shift_done_o goes to 0 on the strobe edge that loads a character. It goes to 1 on the strobe edge that begins the last stop bit, provided the holding register is empty at that edge.
- R8: irq_o is a one-cycle pulse in the first cycle that the selected flag is 1 after being 0. irq_on_done_i at 0 selects buf_empty_o; at 1 it selects shift_done_o.
- R9: If the holding register is full when the last stop bit ends, the next start bit follows on the very next bit period.
- R10: A write to a full holding register replaces the held character. The replaced character is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle pulse per bit period |
| len8_i | input | 1 | 1: eight data bits, 0: seven |
| par_en_i | input | 1 | Append a parity bit |
| par_odd_i | input | 1 | 1: odd parity, 0: even |
| stop2_i | input | 1 | 1: two stop bits, 0: one |
| irq_on_done_i | input | 1 | Interrupt source: 1 shift done, 0 buffer empty |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character to send |
| txd_o | output | 1 | Serial line |
| buf_empty_o | output | 1 | Holding register empty |
| shift_done_o | output | 1 | Shifter idle, or in its last stop bit with nothing held |
| irq_o | output | 1 | Transmit interrupt pulse |

## Verification
buf_empty_o is due low one cycle after the write edge. A load happens on the first strobe edge at which a character is held and the shifter is idle or in its last bit. On that edge the start bit, the rise of buf_empty_o and the fall of shift_done_o all appear together. Every later bit, and the rise of shift_done_o at the start of the last stop bit, lands on one further strobe edge each. irq_o is due in the same cycle as the flag it follows. The bench drives on falling edges and samples the line only at the falling edge right after a strobe edge. At that instant it compares each bit, and the two flags, with the frame it computed when it queued the character.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic len_full;
    logic par_en;
    logic par_odd;
    logic stop2;
  } frame_cfg_t;
endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_en_i) begin
      // a write wins over a same-cycle take; the old value is loaded
      full_o <= 1'b1;
      data_o <= wr_data_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end

  assert_wr_fills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> full_o);
  assert_empty_by_take_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(take_i));
  assert_wr_replaces_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> data_o == $past(wr_data_i));
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  frame_cfg_t        cfg_i,
  input  logic              buf_full_i,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic              take_o,
  output logic              txd_o,
  output logic              done_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]   left_q, len_d;
  logic               last_bit;
  logic               par_bit;
  logic [DATA_W-1:0]  dmask;

  always_comb begin
    dmask = cfg_i.len_full ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
    par_bit = (^(buf_data_i & dmask)) ^ cfg_i.par_odd;
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (dmask[i]) frame_d[1+i] = buf_data_i[i];
    end
    if (cfg_i.par_en) begin
      if (cfg_i.len_full) frame_d[1+DATA_W] = par_bit;
      else                frame_d[DATA_W]   = par_bit;
    end
    len_d = CNT_W'(DATA_W) + (cfg_i.len_full ? CNT_W'(1) : CNT_W'(0))
          + (cfg_i.par_en ? CNT_W'(1) : CNT_W'(0))
          + (cfg_i.stop2 ? CNT_W'(2) : CNT_W'(1));
  end

  assign last_bit = busy_q && (left_q == CNT_W'(1));
  assign take_o   = bit_stb_i && buf_full_i && (!busy_q || last_bit);
  assign txd_o    = busy_q ? frame_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      left_q  <= '0;
      done_o  <= 1'b1;
    end else if (take_o) begin
      busy_q  <= 1'b1;
      frame_q <= frame_d;
      left_q  <= len_d;
      done_o  <= 1'b0;
    end else if (bit_stb_i && busy_q) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      left_q  <= left_q - CNT_W'(1);
      if (last_bit) busy_q <= 1'b0;
      // entering the final stop bit with nothing held
      if (left_q == CNT_W'(2) && !buf_full_i) done_o <= 1'b1;
    end
  end

  assert_txd_on_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(bit_stb_i));
  assert_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !txd_o);
  assert_done_clears_on_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !done_o);
endmodule

// File: rtl/tx_irq_sel.sv
module tx_irq_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_done_i,
  input  logic empty_i,
  input  logic done_i,
  output logic irq_o
);
  logic empty_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      done_q  <= 1'b1;
    end else begin
      empty_q <= empty_i;
      done_q  <= done_i;
    end
  end

  assign irq_o = sel_done_i ? (done_i & ~done_q) : (empty_i & ~empty_q);

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              len8_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              irq_on_done_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              shift_done_o,
  output logic              irq_o
);
  frame_cfg_t        cfg;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              take;

  assign cfg = '{len_full: len8_i, par_en: par_en_i, par_odd: par_odd_i, stop2: stop2_i};
  assign buf_empty_o = ~buf_full;

  tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .take_i (take),
    .full_o (buf_full),
    .data_o (buf_data)
  );

  tx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .bit_stb_i,
    .cfg_i      (cfg),
    .buf_full_i (buf_full),
    .buf_data_i (buf_data),
    .take_o     (take),
    .txd_o      (txd_o),
    .done_o     (shift_done_o)
  );

  tx_irq_sel u_irq (
    .clk_i, .rst_ni,
    .sel_done_i (irq_on_done_i),
    .empty_i    (buf_empty_o),
    .done_i     (shift_done_o),
    .irq_o      (irq_o)
  );

  assert_irq_on_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(shift_done_o) && irq_on_done_i) |-> irq_o);
  assert_load_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_empty_o) |-> !txd_o);
endmodule

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;
  localparam int DIV = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bit_stb = 1'b0, len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0, irq_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, buf_empty, shift_done, irq;

  always #5 clk = ~clk;

  uart_tx_dbuf uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_stb_i(bit_stb), .len8_i(len8), .par_en_i(par_en),
    .par_odd_i(par_odd), .stop2_i(stop2), .irq_on_done_i(irq_sel), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .txd_o(txd), .buf_empty_o(buf_empty), .shift_done_o(shift_done),
    .irq_o(irq)
  );

  int checks = 0, fails = 0;
  logic [11:0] exp_vec[$];
  int          exp_len[$];
  string       exp_tag[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor state
  int  stb_idx = 0, div_cnt = 0, bit_idx = 0, last_end = -10, frames_done = 0, irq_pulses = 0;
  bit  in_frame = 0, expect_b2b = 0;
  bit  sd_last, sd_prev, sd_q = 1, be_q = 1;
  logic [11:0] got, cur_vec;
  int  cur_len;
  string cur_tag;

  always @(negedge clk) begin
    if (rst_ni) begin
      // R8: irq follows the rise of the selected flag
      begin
        bit e;
        e = irq_sel ? (shift_done && !sd_q) : (buf_empty && !be_q);
        if (e || irq) chk(irq == e, "R8 irq pulse", irq, e);
        if (irq) irq_pulses++;
      end
      sd_q = shift_done;
      be_q = buf_empty;
      if (bit_stb) begin
        stb_idx++;
        if (!in_frame) begin
          if (!txd) begin
            if (exp_vec.size() == 0) chk(0, "R2 unexpected start", 0, 1);
            else begin
              cur_vec = exp_vec.pop_front();
              cur_len = exp_len.pop_front();
              cur_tag = exp_tag.pop_front();
              got = '1; got[0] = 1'b0; bit_idx = 1; in_frame = 1;
              chk(buf_empty == 1'b1, "R6 empty at load", buf_empty, 1);
              chk(shift_done == 1'b0, "R7 done cleared at load", shift_done, 0);
              if (expect_b2b) begin
                chk(stb_idx == last_end + 1, "R9 back-to-back start", stb_idx, last_end + 1);
                expect_b2b = 0;
              end
            end
          end
        end else begin
          got[bit_idx] = txd;
          if (bit_idx == cur_len - 2) sd_prev = shift_done;
          if (bit_idx == cur_len - 1) begin
            sd_last = shift_done;
            chk(got == cur_vec, cur_tag, got, cur_vec);
            in_frame = 0;
            last_end = stb_idx;
            frames_done++;
          end
          bit_idx++;
        end
      end
      div_cnt = (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
      bit_stb <= (div_cnt == 0);
    end
  end

  function automatic void expect_frame(input logic [7:0] d, input string tag);
    logic [11:0] v;
    int n, l;
    logic p;
    v = '1; v[0] = 1'b0;
    n = len8 ? 8 : 7;
    p = par_odd;
    for (int i = 0; i < n; i++) begin
      v[1+i] = d[i];
      p ^= d[i];
    end
    if (par_en) v[1+n] = p;
    l = 1 + n + (par_en ? 1 : 0) + (stop2 ? 2 : 1);
    exp_vec.push_back(v);
    exp_len.push_back(l);
    exp_tag.push_back(tag);
  endfunction

  task automatic write_raw(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input string tag);
    while (!buf_empty) @(negedge clk);
    expect_frame(d, tag);
    write_raw(d);
    chk(buf_empty == 1'b0, "R6 empty falls after write", buf_empty, 0);
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((exp_vec.size() != 0 || in_frame || !shift_done) && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (2 * DIV) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(shift_done == 1'b1, "R1 shift_done", shift_done, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rst_ni = 1'b1;

    // all eight formats, single frames; R2 R3 R4 R5 R7
    for (int f = 0; f < 8; f++) begin
      len8 = f[0]; par_en = f[1]; stop2 = f[2]; par_odd = f[0] ^ f[2];
      irq_sel = f[1];
      irq_pulses = 0;
      send(f[0] ? 8'hA5 : 8'hD3, "R2 R3 R4 R5 frame bits");
      wait_idle();
      chk(sd_last == 1'b1, "R7 done set at last stop bit", sd_last, 1);
      chk(sd_prev == 1'b0, "R7 done low before last stop bit", sd_prev, 0);
      chk(irq_pulses == 1, "R8 one pulse per frame", irq_pulses, 1);
    end

    // R3: bit 7 ignored in seven-bit mode, both values of it
    len8 = 1'b0; par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b0;
    send(8'h80, "R3 bit7 ignored");
    wait_idle();
    send(8'h7F, "R3 seven ones");
    wait_idle();

    // R9: back-to-back frames
    len8 = 1'b1; par_en = 1'b0; stop2 = 1'b1;
    send(8'h3C, "R9 first frame");
    send(8'hC3, "R9 second frame");
    expect_b2b = 1;
    wait_idle();
    chk(frames_done == 12, "R9 frame count", frames_done, 12);

    // R10: overwrite while full
    par_en = 1'b1; par_odd = 1'b1; stop2 = 1'b0;
    send(8'h11, "R10 first frame");
    while (!buf_empty) @(negedge clk);
    write_raw(8'h22);
    expect_frame(8'h33, "R10 replacement sent");
    write_raw(8'h33);
    wait_idle();
    chk(frames_done == 14, "R10 replaced char not sent", frames_done, 14);

    // streamed data with varied patterns
    begin
      logic [7:0] lf = 8'h5B;
      len8 = 1'b1; par_en = 1'b1; par_odd = 1'b0; stop2 = 1'b1; irq_sel = 1'b0;
      for (int k = 0; k < 10; k++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        send(lf, "R2 R4 stream");
      end
      wait_idle();
    end
    chk(txd == 1'b1, "R2 line idle high", txd, 1);
    chk(exp_vec.size() == 0, "R2 all frames seen", exp_vec.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule